// File: doc/BRIEF.md
# Packet-Counted Circular Buffer DMA

This block runs one packet channel, of the asynchronous or control kind, through a circular byte region of a shared buffer RAM. A producer presents packet bytes marked with start and end flags. A consumer drains whole packets in arrival order. The region starts at a configurable base address and spans `cfg_depth + 1` bytes. The write pointer and read pointer are byte offsets into the region. The RAM address of each access is the base plus that offset.

Two 8-bit packet counters sit beside the byte pointers. The write counter advances on every stored end byte. The read counter advances on every drained end byte. Pointer equality alone cannot tell a full buffer from an empty one, so the two counters are used to settle which it is. The consumer only sees packets that are already complete, so an abort can take back a partial packet without ever exposing it.

A mute request halts each side at its next packet boundary. A break from the producer discards the packet in progress. Break and protocol-error events land in sticky 5-bit status words.

Top module: `pcb_dma`

## Requirements
- R1: After reset, both pointers and both packet counters are zero, `buf_empty` is 1, `buf_full` is 0, `rd_valid` is 0, `wr_ready` is 1 and both status words are 0.
- R2: `wr_addr` equals `cfg_base` plus the write pointer, and `rd_addr` equals `cfg_base` plus the read pointer, both modulo 2^14. A pointer that has reached `cfg_depth` steps back to 0.
- R3: Bytes are delivered in the order written. `rd_sop` marks the first byte of a packet and `rd_eop` marks the last. `rd_valid` stays 0 until at least one whole packet is stored.
- R4: `wr_pkt_cnt` adds one for each accepted end byte. `rd_pkt_cnt` adds one for each drained end byte. Both counters are 8 bits wide and wrap from 255 to 0.
- R5: `buf_empty` is 1 when the pointers are equal, the counters are equal and no packet is half written. `buf_full` is 1 when the pointers are equal and either the counters differ or a packet is half written. The two flags are never 1 together.
- R6: While `buf_full` is 1, `wr_ready` is 0. Writing resumes once the consumer frees a byte.
- R7: While `mute` is 1, neither side starts a new packet: `wr_ready` is 0 with no packet open, and `rd_valid` is 0 between packets. A packet already in progress finishes on either side.
- R8: A `wr_break` pulse drops the open packet and returns the write pointer to that packet's first byte. In the same cycle `wr_ready` is 0. The pulse sets `wr_status` bit 4.
- R9: An accepted byte without its start flag while no packet is open is discarded. An accepted start byte while a packet is open restarts storage at the open packet's first byte. Either case sets `wr_status` bit 2.
- R10: `rd_break` sets `rd_status` bit 4 and `rd_proto_err` sets `rd_status` bit 2. Status bits stay set until reset, and bits 0, 1 and 3 of both words stay 0.
- R11: When an end byte is written and an end byte is drained in the same cycle, both counters advance and no packet is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 14 | Region base address in the buffer RAM |
| cfg_depth | input | 12 | Region size in bytes minus one |
| mute | input | 1 | Halt both sides at the next packet boundary |
| wr_valid | input | 1 | Producer byte present |
| wr_sop | input | 1 | Producer byte is a packet's first |
| wr_eop | input | 1 | Producer byte is a packet's last |
| wr_data | input | 8 | Producer byte |
| wr_break | input | 1 | Producer break: drop the open packet |
| wr_ready | output | 1 | Producer byte accepted this cycle when valid |
| rd_ready | input | 1 | Consumer takes the presented byte |
| rd_break | input | 1 | Break command from the consumer |
| rd_proto_err | input | 1 | Protocol-error response from the consumer |
| rd_valid | output | 1 | Byte presented to the consumer |
| rd_sop | output | 1 | Presented byte is a packet's first |
| rd_eop | output | 1 | Presented byte is a packet's last |
| rd_data | output | 8 | Presented byte |
| wr_addr | output | 14 | RAM address of the next write |
| rd_addr | output | 14 | RAM address of the next read |
| wr_pkt_cnt | output | 8 | Write packet counter |
| rd_pkt_cnt | output | 8 | Read packet counter |
| buf_full | output | 1 | Region full |
| buf_empty | output | 1 | Region empty |
| wr_status | output | 5 | Write status: bit 4 break, bit 2 protocol error |
| rd_status | output | 5 | Read status: bit 4 break, bit 2 protocol error |

## Verification
Two events can land on the same clock edge:
- **Packet completion on both sides.** The producer's end byte can complete one packet while the consumer drains the end byte of another. The bench provokes this with a long run of short packets, written one byte per cycle while the consumer reads every cycle, so the two counter updates keep coinciding. The result is judged by the scoreboard seeing every byte in order, and by both counters ending at the expected total modulo 256 with the region empty.
- **Break against a new byte.** A break can arrive in the very cycle a byte is offered. The bench asserts both together and expects `wr_ready` to be 0. It then expects the write address to fall back to the start of the dropped packet.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned PTR_W     = 12;
  localparam int unsigned ADDR_W    = 14;
  localparam int unsigned CNT_W     = 8;
  localparam int unsigned STS_W     = 5;
  localparam int unsigned STS_PROTO = 2;
  localparam int unsigned STS_BREAK = 4;

  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [STS_W-1:0]  sts_t;

  // advance a byte offset, wrapping after the last byte of the region
  function automatic ptr_t ptr_step(ptr_t p, ptr_t depth);
    return (p == depth) ? '0 : p + ptr_t'(1);
  endfunction

  function automatic addr_t ram_addr(addr_t base, ptr_t p);
    return base + addr_t'(p);
  endfunction

  function automatic logic ring_full(ptr_t wp, ptr_t rp, cnt_t wc, cnt_t rc, logic open);
    return (wp == rp) && ((wc != rc) || open);
  endfunction

  function automatic logic ring_empty(ptr_t wp, ptr_t rp, cnt_t wc, cnt_t rc, logic open);
    return (wp == rp) && (wc == rc) && !open;
  endfunction

  function automatic sts_t pack_sts(logic brk, logic proto);
    sts_t s;
    s            = '0;
    s[STS_BREAK] = brk;
    s[STS_PROTO] = proto;
    return s;
  endfunction
endpackage

// File: rtl/pcb_store.sv
module pcb_store #(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned WORD_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wword,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rword
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [WORD_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wword;
  end

  assign rword = mem[ridx];
endmodule

// File: rtl/pcb_wr_ctrl.sv
module pcb_wr_ctrl
  import pcb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ptr_t depth,
  input  logic mute,
  input  logic wr_valid,
  input  logic wr_sop,
  input  logic wr_eop,
  input  logic wr_break,
  input  ptr_t rptr,
  input  cnt_t rcnt,
  output logic wr_ready,
  output ptr_t wptr,
  output cnt_t wcnt,
  output logic open,
  output logic mem_we,
  output ptr_t mem_ptr,
  output sts_t wsts,
  output logic wr_commit
);
  ptr_t wstart;
  logic full, take, stray, restart;
  logic sts_brk, sts_proto;

  // named events
  assign full     = ring_full(wptr, rptr, wcnt, rcnt, open);
  assign wr_ready = !full && !wr_break && !(mute && !open);
  assign take     = wr_valid && wr_ready;
  assign stray    = take && !open && !wr_sop;
  assign restart  = take && open && wr_sop;
  assign mem_we   = take && !stray;
  assign mem_ptr  = restart ? wstart : wptr;
  assign wr_commit = mem_we && wr_eop;
  assign wsts     = pack_sts(sts_brk, sts_proto);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      wstart    <= '0;
      wcnt      <= '0;
      open      <= 1'b0;
      sts_brk   <= 1'b0;
      sts_proto <= 1'b0;
    end else begin
      if (wr_break) begin
        wptr    <= wstart;
        open    <= 1'b0;
        sts_brk <= 1'b1;
      end else if (mem_we) begin
        wptr <= ptr_step(mem_ptr, depth);
        if (wr_eop) begin
          wstart <= ptr_step(mem_ptr, depth);
          open   <= 1'b0;
          wcnt   <= wcnt + cnt_t'(1);
        end else begin
          open <= 1'b1;
        end
      end
      if (stray || restart) sts_proto <= 1'b1;
    end
  end

  assert_break_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_break |=> (wptr == $past(wstart)) && !open);
  assert_wcnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt != $past(wcnt)) |-> ($past(wr_commit) && wcnt == $past(wcnt) + cnt_t'(1)));
  assert_wsts_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_brk || sts_proto) |=> (sts_brk >= $past(sts_brk)) && (sts_proto >= $past(sts_proto)));
  assert_no_write_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !open) |=> (wptr == $past(wptr)) || $past(wr_break));
endmodule

// File: rtl/pcb_rd_ctrl.sv
module pcb_rd_ctrl
  import pcb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ptr_t depth,
  input  logic mute,
  input  logic rd_ready,
  input  logic rd_break,
  input  logic rd_proto_err,
  input  cnt_t wcnt,
  input  logic mem_eop,
  output logic rd_valid,
  output logic rd_sop,
  output ptr_t rptr,
  output cnt_t rcnt,
  output sts_t rsts,
  output logic rd_commit
);
  logic in_pkt, avail, take;
  logic sts_brk, sts_proto;

  assign avail     = wcnt != rcnt;
  assign rd_valid  = avail && !(mute && !in_pkt);
  assign rd_sop    = !in_pkt;
  assign take      = rd_valid && rd_ready;
  assign rd_commit = take && mem_eop;
  assign rsts      = pack_sts(sts_brk, sts_proto);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr      <= '0;
      rcnt      <= '0;
      in_pkt    <= 1'b0;
      sts_brk   <= 1'b0;
      sts_proto <= 1'b0;
    end else begin
      if (take) begin
        rptr <= ptr_step(rptr, depth);
        if (mem_eop) begin
          rcnt   <= rcnt + cnt_t'(1);
          in_pkt <= 1'b0;
        end else begin
          in_pkt <= 1'b1;
        end
      end
      if (rd_break)     sts_brk   <= 1'b1;
      if (rd_proto_err) sts_proto <= 1'b1;
    end
  end

  assert_midpacket_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !mem_eop) |=> rd_valid && !rd_sop);
  assert_rcnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rcnt != $past(rcnt)) |-> ($past(rd_commit) && rcnt == $past(rcnt) + cnt_t'(1)));
  assert_rsts_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_break) |-> rsts[STS_BREAK]);
endmodule

// File: rtl/pcb_dma.sv
module pcb_dma
  import pcb_pkg::*;
#(
  parameter int unsigned STORE_AW = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:0] cfg_base,
  input  logic [11:0] cfg_depth,
  input  logic        mute,
  input  logic        wr_valid,
  input  logic        wr_sop,
  input  logic        wr_eop,
  input  logic [7:0]  wr_data,
  input  logic        wr_break,
  output logic        wr_ready,
  input  logic        rd_ready,
  input  logic        rd_break,
  input  logic        rd_proto_err,
  output logic        rd_valid,
  output logic        rd_sop,
  output logic        rd_eop,
  output logic [7:0]  rd_data,
  output logic [13:0] wr_addr,
  output logic [13:0] rd_addr,
  output logic [7:0]  wr_pkt_cnt,
  output logic [7:0]  rd_pkt_cnt,
  output logic        buf_full,
  output logic        buf_empty,
  output logic [4:0]  wr_status,
  output logic [4:0]  rd_status
);
  localparam int unsigned WORD_W = 9;

  ptr_t  wptr, rptr, mem_ptr;
  cnt_t  wcnt, rcnt;
  logic  open, mem_we, wr_commit, rd_commit;
  addr_t store_waddr;
  logic [WORD_W-1:0] rword;

  pcb_wr_ctrl i_wr (
    .clk(clk), .rst_n(rst_n), .depth(cfg_depth), .mute(mute),
    .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_break(wr_break),
    .rptr(rptr), .rcnt(rcnt), .wr_ready(wr_ready), .wptr(wptr), .wcnt(wcnt),
    .open(open), .mem_we(mem_we), .mem_ptr(mem_ptr), .wsts(wr_status),
    .wr_commit(wr_commit)
  );

  pcb_rd_ctrl i_rd (
    .clk(clk), .rst_n(rst_n), .depth(cfg_depth), .mute(mute),
    .rd_ready(rd_ready), .rd_break(rd_break), .rd_proto_err(rd_proto_err),
    .wcnt(wcnt), .mem_eop(rword[8]), .rd_valid(rd_valid), .rd_sop(rd_sop),
    .rptr(rptr), .rcnt(rcnt), .rsts(rd_status), .rd_commit(rd_commit)
  );

  assign store_waddr = ram_addr(cfg_base, mem_ptr);
  assign wr_addr     = ram_addr(cfg_base, wptr);
  assign rd_addr     = ram_addr(cfg_base, rptr);

  pcb_store #(.IDX_W(STORE_AW), .WORD_W(WORD_W)) i_store (
    .clk(clk), .we(mem_we), .widx(store_waddr[STORE_AW-1:0]),
    .wword({wr_eop, wr_data}), .ridx(rd_addr[STORE_AW-1:0]), .rword(rword)
  );

  assign rd_eop     = rword[8];
  assign rd_data    = rword[7:0];
  assign wr_pkt_cnt = wcnt;
  assign rd_pkt_cnt = rcnt;
  assign buf_full   = ring_full(wptr, rptr, wcnt, rcnt, open);
  assign buf_empty  = ring_empty(wptr, rptr, wcnt, rcnt, open);

  assert_full_empty_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty));
  assert_both_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && rd_commit) |=> (wcnt - rcnt) == $past(wcnt - rcnt));
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> buf_empty && !rd_valid);
endmodule

// File: tb/test_pcb_dma.sv
module test_pcb_dma;
  localparam logic [13:0] BASE  = 14'h3F8;
  localparam logic [11:0] DEPTH = 12'd15;
  localparam int          SIZE  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mute = 0, wr_valid = 0, wr_sop = 0, wr_eop = 0, wr_break = 0;
  logic [7:0] wr_data = '0;
  logic rd_ready = 0, rd_break = 0, rd_proto_err = 0;
  logic wr_ready, rd_valid, rd_sop, rd_eop, buf_full, buf_empty;
  logic [7:0] rd_data, wr_pkt_cnt, rd_pkt_cnt;
  logic [13:0] wr_addr, rd_addr;
  logic [4:0] wr_status, rd_status;

  int checks = 0, errors = 0;
  int exp_wp = 0, exp_cnt = 0;
  logic rd_en = 0;
  logic [9:0] sb[$];

  always #4 clk = ~clk;

  pcb_dma i_pcb_dma (
    .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_depth(DEPTH), .mute(mute),
    .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_data(wr_data),
    .wr_break(wr_break), .wr_ready(wr_ready), .rd_ready(rd_ready),
    .rd_break(rd_break), .rd_proto_err(rd_proto_err), .rd_valid(rd_valid),
    .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_data(rd_data), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .wr_pkt_cnt(wr_pkt_cnt), .rd_pkt_cnt(rd_pkt_cnt),
    .buf_full(buf_full), .buf_empty(buf_empty), .wr_status(wr_status),
    .rd_status(rd_status)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int addr_of(int off);
    return (int'(BASE) + off) % 16384;
  endfunction

  task automatic put(bit s, bit e, logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_sop = s; wr_eop = e; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_valid = 0; wr_sop = 0; wr_eop = 0;
  endtask

  // driver: expected bytes go to the scoreboard before being written
  task automatic send(int len, logic [7:0] seed);
    for (int i = 0; i < len; i++) sb.push_back({i == 0, i == len - 1, seed + 8'(i)});
    for (int i = 0; i < len; i++) put(i == 0, i == len - 1, seed + 8'(i));
    exp_wp  = (exp_wp + len) % SIZE;
    exp_cnt = exp_cnt + 1;
  endtask

  task automatic set_rd(logic v);
    @(posedge clk); #1; rd_en = v;
  endtask

  task automatic drain;
    set_rd(1);
    @(negedge clk);
    while (!(buf_empty && sb.size() == 0)) @(negedge clk);
    #2;
  endtask

  // monitor: compares each consumed byte with the scoreboard head
  initial forever begin
    @(negedge clk);
    rd_ready = rd_en;
    #1;
    if (rst_n && rd_valid && rd_ready) begin
      if (sb.size() == 0) chk("R3 unexpected byte", int'(rd_data), -1);
      else begin
        logic [9:0] item;
        item = sb.pop_front();
        chk("R3 byte order and markers", int'({rd_sop, rd_eop, rd_data}), int'(item));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk("R1 empty", int'(buf_empty), 1);
    chk("R1 full", int'(buf_full), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 wr_ready", int'(wr_ready), 1);
    chk("R1 wcnt", int'(wr_pkt_cnt), 0);
    chk("R1 rcnt", int'(rd_pkt_cnt), 0);
    chk("R1 wr_addr", int'(wr_addr), addr_of(0));
    chk("R1 status", int'({wr_status, rd_status}), 0);

    // R3: partial packet is invisible to the consumer
    for (int i = 0; i < 3; i++) sb.push_back({i == 0, i == 2, 8'h10 + 8'(i)});
    put(1, 0, 8'h10); put(0, 0, 8'h11);
    chk("R3 partial hidden", int'(rd_valid), 0);
    chk("R5 not empty mid packet", int'(buf_empty), 0);
    put(0, 1, 8'h12);
    exp_wp = 3; exp_cnt = 1;
    chk("R3 whole packet shown", int'(rd_valid), 1);
    chk("R4 wcnt after eop", int'(wr_pkt_cnt), 1);
    chk("R2 wr_addr", int'(wr_addr), addr_of(3));
    drain();
    chk("R4 rcnt after drain", int'(rd_pkt_cnt), 1);
    chk("R2 rd_addr", int'(rd_addr), addr_of(3));
    set_rd(0);

    // R5/R6: fill the region exactly, wrapping the address
    for (int k = 0; k < 4; k++) send(4, 8'h20 + 8'(k * 4));
    #1;
    chk("R5 full", int'(buf_full), 1);
    chk("R5 not empty when full", int'(buf_empty), 0);
    chk("R2 wrapped wr_addr", int'(wr_addr), addr_of(3));
    @(negedge clk); wr_valid = 1; wr_sop = 1; wr_eop = 1; #1;
    chk("R6 stall when full", int'(wr_ready), 0);
    @(negedge clk); wr_valid = 0; wr_sop = 0; wr_eop = 0;
    fork
      send(1, 8'hA0);
      begin
        repeat (5) @(posedge clk); #1;
        chk("R6 still stalled", int'(wr_pkt_cnt), 5);
        rd_en = 1;
      end
    join
    drain();
    chk("R6 resumed", int'(wr_pkt_cnt), 6);
    chk("R5 empty after drain", int'(buf_empty), 1);
    set_rd(0);

    // R7: mute lets the open packet finish, holds new ones
    for (int i = 0; i < 3; i++) sb.push_back({i == 0, i == 2, 8'hB0 + 8'(i)});
    put(1, 0, 8'hB0);
    @(negedge clk); mute = 1;
    put(0, 0, 8'hB1); put(0, 1, 8'hB2);
    exp_wp = (exp_wp + 3) % SIZE; exp_cnt++;
    chk("R7 open packet finished", int'(wr_pkt_cnt), 7);
    @(negedge clk); wr_valid = 1; wr_sop = 1; wr_eop = 1; #1;
    chk("R7 new packet held", int'(wr_ready), 0);
    chk("R7 reader held", int'(rd_valid), 0);
    rd_en = 1;
    repeat (3) @(negedge clk);
    wr_valid = 0; wr_sop = 0; wr_eop = 0; #2;
    chk("R7 no write under mute", int'(wr_pkt_cnt), 7);
    chk("R7 no read under mute", int'(rd_pkt_cnt), 6);
    @(negedge clk); mute = 0;
    drain();
    chk("R7 delivered after unmute", int'(rd_pkt_cnt), 7);
    set_rd(0);

    // R8: break drops the open packet
    put(1, 0, 8'hC0); put(0, 0, 8'hC1);
    chk("R8 addr before break", int'(wr_addr), addr_of(exp_wp + 2));
    @(negedge clk); wr_valid = 1; wr_break = 1; #1;
    chk("R8 ready low on break", int'(wr_ready), 0);
    @(negedge clk); wr_valid = 0; wr_break = 0; #2;
    chk("R8 rewind", int'(wr_addr), addr_of(exp_wp));
    chk("R8 status", int'(wr_status), 5'b10000);
    chk("R8 count unchanged", int'(wr_pkt_cnt), 7);
    send(2, 8'hD0);
    drain();
    set_rd(0);

    // R9: marker errors
    put(0, 1, 8'hE0);
    chk("R9 stray discarded", int'(wr_addr), addr_of(exp_wp));
    chk("R9 stray count", int'(wr_pkt_cnt), 8);
    chk("R9 status", int'(wr_status), 5'b10100);
    put(1, 0, 8'hF0); put(0, 0, 8'hF1);
    send(3, 8'h60);
    drain();
    chk("R9 restart addr", int'(wr_addr), addr_of(exp_wp));
    chk("R9 restart count", int'(wr_pkt_cnt), 9);

    // R10: consumer status
    @(negedge clk); rd_break = 1; @(negedge clk); rd_break = 0; #2;
    chk("R10 rd break", int'(rd_status), 5'b10000);
    @(negedge clk); rd_proto_err = 1; @(negedge clk); rd_proto_err = 0;
    repeat (3) @(negedge clk); #2;
    chk("R10 rd sticky", int'(rd_status), 5'b10100);
    chk("R10 wr sticky", int'(wr_status), 5'b10100);

    // R4/R11: counter wrap with simultaneous commits
    for (int k = 0; k < 250; k++) send(1 + (k % 3), 8'(k));
    drain();
    chk("R4 wcnt wrap", int'(wr_pkt_cnt), exp_cnt % 256);
    chk("R11 rcnt matches", int'(rd_pkt_cnt), exp_cnt % 256);
    chk("R2 final wr_addr", int'(wr_addr), addr_of(exp_wp));
    chk("R2 final rd_addr", int'(rd_addr), addr_of(exp_wp));
    chk("R11 empty at end", int'(buf_empty), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule